// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block is the status-register part of the slave side of an SPI (mode 0) serial flash. The host drives serial clock, active-low chip select and a data input; the block drives a data output. It decodes three kinds of command: set the write-enable latch, write the status register, and read the status register (low or high byte). It holds a 16-bit status word. Only a correctly framed write that is enabled and not locked by hardware protection is accepted. An accepted write then runs a self-timed busy period of a set number of system clocks.

All SPI pins and the active-low write-protect pin are resynchronised into the system clock domain `clk`. The serial clock must therefore run well below `clk`; at least six system clocks per half period leaves margin over the synchroniser. The busy-period length is the parameter `BUSY_CYCLES`. A write is committed to the register, and the write-enable latch is cleared, only when the busy period ends. Commands are sampled MSB first on rising serial clock. Read data is driven on falling serial clock.

Top module: `sflash_status_ctrl`

## Requirements
- R1: After reset the status word is 0x0000 and the data output is 0.
- R2: Opcode 0x06, with chip select rising after exactly 8 serial clocks, sets the write-enable latch, which reads as status bit 1.
- R3: Opcode 0x05 returns status bits 7..0 and opcode 0x35 returns bits 15..8, MSB first. Each bit is driven after a falling serial clock. The byte repeats for as long as chip select stays low, and the output is 0 while chip select is high.
- R4: Opcode 0x01 (status write) has no effect when the write-enable latch is clear.
- R5: A status write whose chip select rises after exactly 16 serial clocks (opcode plus one byte) loads bits 2..7 from the byte and forces bits 8, 9 and 14 to 0.
- R6: A status write whose chip select rises after exactly 24 serial clocks loads the first data byte into bits 7..0 and the second into bits 15..8.
- R7: A status write ending after any other number of serial clocks (8, 15, 17, 25 and so on) is discarded: the status word and the write-enable latch are unchanged.
- R8: The writable bits are 2..9 and 14. Bits 0, 1, 10..13 and 15 are never loaded from write data, and bits 10..13 and 15 always read 0.
- R9: An accepted write sets status bit 0 (busy) for `BUSY_CYCLES` clocks. The status stays readable during that time with bits 0 and 1 both at 1. When the period ends, the new value appears and bits 0 and 1 read 0.
- R10: When bit 8 is 0, bit 7 is 1 and `wp_n` is low, status writes are ignored and the latch stays set. With `wp_n` high the same write is accepted.
- R11: A status write issued during the busy period is ignored.
- R12: Any other opcode changes nothing and leaves the data output at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| wp_n | input | 1 | Active-low hardware write protect |

## Verification
A wrong bit counter or a wrongly captured opcode shows up as a discarded or misloaded write. This is seen one full frame later, when the status is read back over the serial port. A stuck or miscounted busy counter shows as a busy bit that is still set, or already clear, on the first read after the expected end of the period. A broken protection decode shows as a status value that changed when it should not have, or stayed the same when it should have changed. The read path checks itself on every frame, because each expectation is compared bit by bit over several repeated bytes.

// File: rtl/sfsr_pkg.sv
package sfsr_pkg;

  localparam logic [7:0] OP_SET_WEL  = 8'h06;
  localparam logic [7:0] OP_WR_STAT  = 8'h01;
  localparam logic [7:0] OP_RD_LOW   = 8'h05;
  localparam logic [7:0] OP_RD_HIGH  = 8'h35;

  // writable status bits: 2..9 and 14
  localparam logic [15:0] STORE_MASK = 16'h43FC;

  // frame bit counter: counts up to WRAP_HI, then cycles in WRAP_LO..WRAP_HI
  localparam int CNT_W   = 6;
  localparam int WRAP_LO = 32;
  localparam int WRAP_HI = 39;

  localparam int LEN_SHORT = 16;
  localparam int LEN_LONG  = 24;

  function automatic logic [CNT_W-1:0] frame_cnt_next(logic [CNT_W-1:0] c);
    if (c == CNT_W'(WRAP_HI)) return CNT_W'(WRAP_LO);
    return c + 1'b1;
  endfunction

  function automatic logic [15:0] merge_status(logic [7:0] lo, logic [7:0] hi, logic two_bytes);
    logic [15:0] raw;
    raw = {(two_bytes ? hi : 8'h00), lo};
    return raw & STORE_MASK;
  endfunction

  function automatic logic hw_locked(logic srp_hi, logic srp_lo, logic wp_n_s);
    return !srp_hi && srp_lo && !wp_n_s;
  endfunction

endpackage

// File: rtl/sfsr_sync.sv
module sfsr_sync #(
  parameter int W = 4,
  parameter int EDGE_W = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      async_in,
  output logic [W-1:0]      sync_q,
  output logic [EDGE_W-1:0] prev_q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= INIT;
      sync_q <= INIT;
    end else begin
      stage1 <= async_in;
      sync_q <= stage1;
    end
  end

  generate
    for (genvar g = 0; g < EDGE_W; g++) begin : g_edge
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q[g] <= INIT[g];
        else        prev_q[g] <= sync_q[g];
      end
    end
  endgenerate
endmodule

// File: rtl/sfsr_frame.sv
module sfsr_frame
  import sfsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_low,
  input  logic             cs_rise,
  input  logic             sclk_rise,
  input  logic             mosi_s,
  output logic [CNT_W-1:0] bit_cnt,
  output logic [7:0]       opcode,
  output logic             wren_req,
  output logic             wrsr_req,
  output logic             wrsr_two,
  output logic [7:0]       data_lo,
  output logic [7:0]       data_hi
);
  logic [15:0] shreg;
  logic        len_short, len_long, len_op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      opcode  <= '0;
      shreg   <= '0;
    end else if (!cs_low) begin
      bit_cnt <= '0;
      opcode  <= '0;
    end else if (sclk_rise) begin
      shreg   <= {shreg[14:0], mosi_s};
      bit_cnt <= frame_cnt_next(bit_cnt);
      if (bit_cnt == CNT_W'(7)) opcode <= {shreg[6:0], mosi_s};
    end
  end

  assign len_op    = (bit_cnt == CNT_W'(8));
  assign len_short = (bit_cnt == CNT_W'(LEN_SHORT));
  assign len_long  = (bit_cnt == CNT_W'(LEN_LONG));

  assign wren_req = cs_rise && len_op && (opcode == OP_SET_WEL);
  assign wrsr_req = cs_rise && (len_short || len_long) && (opcode == OP_WR_STAT);
  assign wrsr_two = len_long;
  assign data_lo  = len_long ? shreg[15:8] : shreg[7:0];
  assign data_hi  = shreg[7:0];

  AST_WREN_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    wren_req |-> !wrsr_req);  // R2
endmodule

// File: rtl/sfsr_status_core.sv
module sfsr_status_core
  import sfsr_pkg::*;
#(
  parameter int BUSY_CYCLES = 200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wren_req,
  input  logic        wrsr_req,
  input  logic        wrsr_two,
  input  logic [7:0]  data_lo,
  input  logic [7:0]  data_hi,
  input  logic        wp_n_s,
  output logic [15:0] status,
  output logic        commit_evt,
  output logic        accept_evt
);
  localparam int BW = $clog2(BUSY_CYCLES + 1);

  logic [15:0]   stored, pend;
  logic          pend_two;
  logic          wel, busy;
  logic [BW-1:0] bcnt;
  logic          locked;

  assign locked     = hw_locked(stored[8], stored[7], wp_n_s);
  assign accept_evt = wrsr_req && wel && !busy && !locked;
  assign commit_evt = busy && (bcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stored   <= '0;
      pend     <= '0;
      pend_two <= 1'b0;
      wel      <= 1'b0;
      busy     <= 1'b0;
      bcnt     <= '0;
    end else begin
      if (accept_evt) begin
        pend     <= merge_status(data_lo, data_hi, wrsr_two);
        pend_two <= wrsr_two;
        busy     <= 1'b1;
        bcnt     <= BW'(BUSY_CYCLES - 1);
      end else if (commit_evt) begin
        stored <= pend;
        busy   <= 1'b0;
      end else if (busy) begin
        bcnt <= bcnt - 1'b1;
      end

      if (commit_evt)    wel <= 1'b0;
      else if (wren_req) wel <= 1'b1;
    end
  end

  assign status = stored | {14'b0, wel, busy};

  AST_STORE_ONLY_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_evt |=> $stable(stored));  // R7
  AST_BUSY_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));  // R4
  AST_WEL_DROPS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);  // R9
  AST_BUSY_KEEPS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> wel);  // R9
  AST_NO_START_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(locked));  // R10
  AST_SHORT_CLEARS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_evt && !pend_two) |=> (stored[15:8] == 8'h00));  // R5
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> (stored[13:10] == 4'h0 && !stored[15]));  // R8
  AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit_evt) |=> busy);  // R11
endmodule

// File: rtl/sfsr_readout.sv
module sfsr_readout
  import sfsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_low,
  input  logic             sclk_fall,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic [7:0]       opcode,
  input  logic [15:0]      status,
  output logic             miso
);
  logic [7:0] hold;
  logic [7:0] live;
  logic       sel_ok;
  logic       active;
  logic [2:0] idx;

  always_comb begin
    sel_ok = 1'b1;
    live   = status[7:0];
    if (opcode == OP_RD_HIGH)     live = status[15:8];
    else if (opcode != OP_RD_LOW) sel_ok = 1'b0;
  end

  assign active = sel_ok && (bit_cnt >= CNT_W'(8));
  assign idx    = ~bit_cnt[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miso <= 1'b0;
      hold <= '0;
    end else if (!cs_low) begin
      miso <= 1'b0;
    end else if (sclk_fall) begin
      if (!active) begin
        miso <= 1'b0;
      end else if (idx == 3'd7) begin
        hold <= live;
        miso <= live[7];
      end else begin
        miso <= hold[idx];
      end
    end
  end

  AST_MISO_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_low |=> !miso);  // R3
  AST_MISO_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_low && !sclk_fall) |=> $stable(miso));  // R3
  AST_MISO_SILENT_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_low && !sel_ok) |=> !miso);  // R12
endmodule

// File: rtl/sflash_status_ctrl.sv
module sflash_status_ctrl
  import sfsr_pkg::*;
#(
  parameter int BUSY_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  input  logic wp_n
);
  // synchronised vector: [3]=wp_n [2]=mosi [1]=cs_n [0]=sclk
  logic [3:0] pins_q;
  logic [1:0] pins_prev;

  logic             cs_low, cs_rise, sclk_rise, sclk_fall;
  logic [CNT_W-1:0] bit_cnt;
  logic [7:0]       opcode, data_lo, data_hi;
  logic             wren_req, wrsr_req, wrsr_two;
  logic [15:0]      status;
  logic             commit_evt, accept_evt;

  sfsr_sync #(.W(4), .EDGE_W(2), .INIT(4'b1010)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in({wp_n, spi_mosi, spi_cs_n, spi_sclk}),
    .sync_q  (pins_q),
    .prev_q  (pins_prev)
  );

  assign cs_low    = !pins_q[1];
  assign cs_rise   = pins_q[1] && !pins_prev[1];
  assign sclk_rise = cs_low && pins_q[0] && !pins_prev[0];
  assign sclk_fall = cs_low && !pins_q[0] && pins_prev[0];

  sfsr_frame u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_low   (cs_low),
    .cs_rise  (cs_rise),
    .sclk_rise(sclk_rise),
    .mosi_s   (pins_q[2]),
    .bit_cnt  (bit_cnt),
    .opcode   (opcode),
    .wren_req (wren_req),
    .wrsr_req (wrsr_req),
    .wrsr_two (wrsr_two),
    .data_lo  (data_lo),
    .data_hi  (data_hi)
  );

  sfsr_status_core #(.BUSY_CYCLES(BUSY_CYCLES)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .wren_req  (wren_req),
    .wrsr_req  (wrsr_req),
    .wrsr_two  (wrsr_two),
    .data_lo   (data_lo),
    .data_hi   (data_hi),
    .wp_n_s    (pins_q[3]),
    .status    (status),
    .commit_evt(commit_evt),
    .accept_evt(accept_evt)
  );

  sfsr_readout u_read (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_low   (cs_low),
    .sclk_fall(sclk_fall),
    .bit_cnt  (bit_cnt),
    .opcode   (opcode),
    .status   (status),
    .miso     (spi_miso)
  );

  AST_ACCEPT_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |-> cs_rise);  // R7
  AST_COMMIT_NOT_WITH_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |-> !accept_evt);  // R11
endmodule

// File: tb/sim_sflash_status_ctrl.sv
module sim_sflash_status_ctrl;
  localparam int BUSY = 1500;
  localparam int H    = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
  logic miso;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;
  logic [15:0] m_store = 16'h0;
  logic        m_wel = 1'b0;

  always #5 clk = ~clk;

  sflash_status_ctrl #(.BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .wp_n(wp_n)
  );

  // field-by-field view of a write
  function automatic logic [15:0] exp_write(logic [7:0] lo, logic [7:0] hi, bit two);
    logic [15:0] r;
    r = 16'h0;
    r[4:2] = lo[4:2];
    r[5]   = lo[5];
    r[6]   = lo[6];
    r[7]   = lo[7];
    if (two) begin
      r[8]  = hi[0];
      r[9]  = hi[1];
      r[14] = hi[6];
    end
    return r;
  endfunction

  function automatic bit exp_locked(logic [15:0] s, logic wp);
    return (s[7] == 1'b1) && (s[8] == 1'b0) && (wp == 1'b0);
  endfunction

  function automatic logic [15:0] exp_status();
    return m_store | {14'b0, m_wel, 1'b0};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic frame(input logic [31:0] tx, input int ntx, input int nrx, output logic [31:0] rx);
    rx = '0;
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < ntx + nrx; i++) begin
      mosi = (i < ntx) ? tx[ntx-1-i] : 1'b0;
      repeat (H) @(negedge clk);
      if (i >= ntx) rx = {rx[30:0], miso};
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
    mosi = 1'b0;
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (2*H) @(negedge clk);
  endtask

  task automatic wren();
    logic [31:0] rx;
    frame(32'h06, 8, 0, rx);
    m_wel = 1'b1;
  endtask

  // sends the first n bits of {01, lo, hi, 00}; updates model; waits out busy
  task automatic wrsr(input logic [7:0] lo, input logic [7:0] hi, input int n, input bit wait_busy);
    logic [31:0] rx;
    logic [31:0] full;
    bit acc;
    full = {8'h01, lo, hi, 8'h00};
    frame(full >> (32 - n), n, 0, rx);
    acc = (n == 16 || n == 24) && m_wel && !exp_locked(m_store, wp_n);
    if (acc) begin
      m_store = exp_write(lo, hi, n == 24);
      m_wel   = 1'b0;
      if (wait_busy) repeat (BUSY + 40) @(negedge clk);
    end
  endtask

  task automatic rd_check(input logic [7:0] op, input int nb, input string tag);
    logic [31:0] rx;
    logic [15:0] e;
    logic [7:0]  eb;
    frame({24'h0, op}, 8, 8*nb, rx);
    e  = exp_status();
    eb = (op == 8'h35) ? e[15:8] : e[7:0];
    for (int b = 0; b < nb; b++)
      chk(rx[8*b +: 8] == eb, tag, {8'h0, rx[8*b +: 8]}, {8'h0, eb});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rx;
    int seed;
    seed = $urandom(32'd4242);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk(miso == 1'b0, "R1 miso after reset", {15'h0, miso}, 16'h0);
    rd_check(8'h05, 1, "R1 low byte");
    rd_check(8'h35, 1, "R1 high byte");

    // R4 write without latch
    wrsr(8'hFC, 8'hFF, 24, 1'b1);
    rd_check(8'h05, 1, "R4 low");
    rd_check(8'h35, 1, "R4 high");

    // R2 latch, R3 repeated read
    wren();
    rd_check(8'h05, 3, "R2 R3 wel and repeat");

    // R9 busy visible, R11 write during busy, R6 R8 full write
    wrsr(8'hFF, 8'hFF, 24, 1'b0);
    frame(32'h05, 8, 8, rx);
    chk(rx[7:0] == 8'h03, "R9 busy low byte", {8'h0, rx[7:0]}, 16'h0003);
    frame({8'h01, 8'h00, 8'h00}, 24, 0, rx);
    repeat (BUSY + 40) @(negedge clk);
    chk(m_store == 16'h43FC, "R8 model sanity", m_store, 16'h43FC);
    rd_check(8'h35, 1, "R6 R8 R11 high after busy");
    rd_check(8'h05, 2, "R9 R11 low after busy");

    // R5 short write clears upper bits
    wren();
    wrsr(8'hFF, 8'h00, 16, 1'b1);
    rd_check(8'h35, 1, "R5 upper cleared");
    rd_check(8'h05, 1, "R5 low loaded");

    // R7 bad lengths
    wren();
    wrsr(8'h00, 8'h00, 15, 1'b1);
    wrsr(8'h00, 8'h00, 17, 1'b1);
    wrsr(8'h00, 8'h00, 8, 1'b1);
    wrsr(8'h00, 8'h00, 25, 1'b1);
    rd_check(8'h05, 1, "R7 discarded, wel kept");

    // R10 hardware lock (SRP0=1, SRP1=0 from R5 step)
    wp_n = 1'b0;
    repeat (4) @(negedge clk);
    wrsr(8'h00, 8'h00, 16, 1'b1);
    rd_check(8'h05, 1, "R10 locked");
    wp_n = 1'b1;
    repeat (4) @(negedge clk);
    wrsr(8'h00, 8'h00, 16, 1'b1);
    rd_check(8'h05, 1, "R10 unlocked");

    // R12 unknown opcode
    frame(32'h9F, 8, 16, rx);
    chk(rx[15:0] == 16'h0, "R12 silent output", rx[15:0], 16'h0);
    rd_check(8'h05, 1, "R12 status unchanged");

    // random mix
    for (int it = 0; it < 25; it++) begin
      int op;
      logic [7:0] lo, hi;
      op = int'($urandom_range(0, 5));
      lo = 8'($urandom);
      hi = 8'($urandom);
      case (op)
        0: wren();
        1: begin if ($urandom_range(0, 3) != 0) wren(); wrsr(lo, hi, 16, 1'b1); end
        2: begin if ($urandom_range(0, 3) != 0) wren(); wrsr(lo, hi, 24, 1'b1); end
        3: begin
             int n;
             n = int'($urandom_range(8, 30));
             if (n == 16 || n == 24) n = n + 1;
             wrsr(lo, hi, n, 1'b1);
           end
        4: begin wp_n = ~wp_n; repeat (4) @(negedge clk); end
        default: frame({24'h0, 8'h20}, 8, 8, rx);
      endcase
      rd_check(8'h05, 1, "R2/R5/R6/R7/R10 random low");
      rd_check(8'h35, 1, "R5/R6/R8/R12 random high");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule